// File: doc/BRIEF.md
# Three-Wire Serial Loader for Divider Settings

This block receives settings for a frequency synthesizer's dividers over three slow wires: a serial data line, a serial clock and a load strobe. All three are brought into the system clock domain through synchronizers, and edges are found there. Each rising edge of the serial clock moves one data bit into a shift register, most significant bit first.

When the load strobe rises, the bit shifted in last acts as a routing flag. A high flag sends the word into the reference latch, which holds a 14-bit reference count and a prescaler select bit. A low flag sends it into the main latch, which holds an 11-bit main count and a 7-bit swallow count. A reference count below the legal minimum is stored as that minimum. The latch that takes the word gives a one-cycle update strobe, so the divider logic next to it can restart its counters.

Top module: `ser_loader`

## Requirements
- R1: Data is sampled on each rising edge of the serial clock and shifted in most significant bit first. Falling edges of the serial clock shift nothing.
- R2: At a transfer, the bit shifted in last (shift register bit 0) selects the target: 1 selects the reference latch and 0 selects the main latch.
- R3: A reference word is 16 bits, sent in this order: the 14-bit reference count (MSB first), then the prescaler select bit, then the flag 1. Bits shifted in earlier than these 16 are ignored.
- R4: A main word is 19 bits, sent in this order: the 11-bit main count (MSB first), then the 7-bit swallow count (MSB first), then the flag 0.
- R5: A transfer happens once per rising edge of the load strobe. While the strobe stays high, more serial clocks change neither latch. A later rising edge transfers whatever the shift register holds at that time.
- R6: A transfer pulses the strobe of the target latch high for exactly one system clock and never pulses the other strobe. The other latch keeps its contents.
- R7: A reference count below 8 is stored as 8. Values from 8 to 16383 are stored unchanged.
- R8: After reset the outputs read: reference count 8, prescaler select 0, swallow 0, main count 0, both strobes low. A load strobe that is already high when reset is released causes no transfer.
- R9: A latch and its strobe update no later than four system clocks after a load-strobe rise at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_ld | input | 1 | Load strobe; transfers on its rising edge (asynchronous) |
| ref_count | output | 14 | Latched reference count, never below 8 |
| presc_sel | output | 1 | Latched prescaler select bit |
| swal_count | output | 7 | Latched swallow count |
| main_count | output | 11 | Latched main count |
| ref_upd | output | 1 | One-cycle pulse when the reference latch is written |
| main_upd | output | 1 | One-cycle pulse when the main latch is written |

## Verification
The bench builds the block with its default parameters: 14-bit reference count, 7-bit swallow count, 11-bit main count, a minimum of 8 and two synchronizer stages. With these widths the 19-bit main word fills the whole shift register. A 16-bit reference word sent after a main word therefore leaves stale high bits that must be ignored. Because the minimum sits far below the top of the count range, random reference counts that include values 0 to 7 reach the clamp boundary next to the full-scale values 16383, 2047 and 127.

// File: rtl/sl_pkg.sv
package sl_pkg;
    // Routing flag values carried in the last serial bit
    typedef enum logic {
        TGT_MAIN = 1'b0,
        TGT_REF  = 1'b1
    } tgt_e;

    localparam int DEF_REF_CNT_W = 14;
    localparam int DEF_SWAL_W    = 7;
    localparam int DEF_MAIN_W    = 11;
    localparam int DEF_REF_MIN   = 8;
    localparam int DEF_SYNC      = 2;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: {STAGES{RST_VAL}}};
        else        st_q <= st_d;
    end

    assign level = st_q.chain[STAGES-1];
endmodule

// File: rtl/sl_shift.sv
module sl_shift #(
    parameter int SR_W = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_lvl,
    input  logic            data_lvl,
    output logic [SR_W-1:0] word
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            sclk_prev;
    } st_t;

    st_t  st_d, st_q;
    logic sclk_rise;

    assign sclk_rise = sclk_lvl & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl;
        if (sclk_rise) st_d.sr = {st_q.sr[SR_W-2:0], data_lvl};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

    // R1
    shift_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> (st_q.sr[0] == $past(data_lvl)));

    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(st_q.sr));
endmodule

// File: rtl/sl_latch.sv
module sl_latch #(
    parameter int REF_CNT_W = 14,
    parameter int SWAL_W    = 7,
    parameter int MAIN_W    = 11,
    parameter int REF_MIN   = 8,
    parameter int SR_W      = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_lvl,
    input  logic [SR_W-1:0]      word,
    output logic [REF_CNT_W-1:0] ref_count,
    output logic                 presc_sel,
    output logic [SWAL_W-1:0]    swal_count,
    output logic [MAIN_W-1:0]    main_count,
    output logic                 ref_upd,
    output logic                 main_upd
);
    import sl_pkg::*;

    localparam int REF_WORD_W  = REF_CNT_W + 2;
    localparam int MAIN_WORD_W = MAIN_W + SWAL_W + 1;
    localparam logic [REF_CNT_W-1:0] MIN_V = REF_CNT_W'(REF_MIN);

    typedef struct packed {
        logic [REF_CNT_W-1:0] rc;
        logic                 ps;
        logic [SWAL_W-1:0]    sw;
        logic [MAIN_W-1:0]    mc;
        logic                 ru;
        logic                 mu;
        logic                 ld_prev;
    } st_t;

    st_t                  st_d, st_q;
    logic                 ld_rise;
    tgt_e                 tgt;
    logic [REF_CNT_W-1:0] rc_raw;

    assign ld_rise = ld_lvl & ~st_q.ld_prev;
    assign tgt     = tgt_e'(word[0]);
    assign rc_raw  = word[REF_WORD_W-1:2];

    always_comb begin
        st_d         = st_q;
        st_d.ld_prev = ld_lvl;
        st_d.ru      = 1'b0;
        st_d.mu      = 1'b0;
        if (ld_rise) begin
            if (tgt == TGT_REF) begin
                st_d.rc = (rc_raw < MIN_V) ? MIN_V : rc_raw;
                st_d.ps = word[1];
                st_d.ru = 1'b1;
            end else begin
                st_d.mc = word[MAIN_WORD_W-1:SWAL_W+1];
                st_d.sw = word[SWAL_W:1];
                st_d.mu = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rc      <= MIN_V;
            st_q.ld_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_count  = st_q.rc;
    assign presc_sel  = st_q.ps;
    assign swal_count = st_q.sw;
    assign main_count = st_q.mc;
    assign ref_upd    = st_q.ru;
    assign main_upd   = st_q.mu;

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_upd && main_upd));

    // R6
    ref_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> !ref_upd);

    // R6
    main_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_upd |=> !main_upd);

    // R7
    ref_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_count >= MIN_V);

    // R5
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd |-> ($stable(ref_count) && $stable(presc_sel)));

    // R5
    main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_upd |-> ($stable(main_count) && $stable(swal_count)));

    // R5
    ld_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ld_lvl) |-> !(ref_upd && $past(ref_upd)));
endmodule

// File: rtl/ser_loader.sv
module ser_loader #(
    parameter int REF_CNT_W   = sl_pkg::DEF_REF_CNT_W,
    parameter int SWAL_W      = sl_pkg::DEF_SWAL_W,
    parameter int MAIN_W      = sl_pkg::DEF_MAIN_W,
    parameter int REF_MIN     = sl_pkg::DEF_REF_MIN,
    parameter int SYNC_STAGES = sl_pkg::DEF_SYNC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_ld,
    output logic [REF_CNT_W-1:0] ref_count,
    output logic                 presc_sel,
    output logic [SWAL_W-1:0]    swal_count,
    output logic [MAIN_W-1:0]    main_count,
    output logic                 ref_upd,
    output logic                 main_upd
);
    localparam int SR_W   = sl_pkg::max2(REF_CNT_W + 2, MAIN_W + SWAL_W + 1);
    localparam int N_SYNC = 3;
    // bit 2 = load strobe (idles high), bit 1 = serial clock, bit 0 = data
    localparam logic [N_SYNC-1:0] SYNC_RST = 3'b100;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] lvl;
    logic [SR_W-1:0]   word;

    assign raw_in = {ser_ld, ser_clk, ser_dat};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        sl_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(SYNC_RST[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .level(lvl[g])
        );
    end

    sl_shift #(.SR_W(SR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_lvl(lvl[1]),
        .data_lvl(lvl[0]),
        .word    (word)
    );

    sl_latch #(
        .REF_CNT_W(REF_CNT_W),
        .SWAL_W   (SWAL_W),
        .MAIN_W   (MAIN_W),
        .REF_MIN  (REF_MIN),
        .SR_W     (SR_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_lvl    (lvl[2]),
        .word      (word),
        .ref_count (ref_count),
        .presc_sel (presc_sel),
        .swal_count(swal_count),
        .main_count(main_count),
        .ref_upd   (ref_upd),
        .main_upd  (main_upd)
    );
endmodule

// File: tb/tb_ser_loader.sv
`timescale 1ns/1ps
module tb_ser_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_ld = 1'b1;
    logic [13:0] ref_count;
    logic        presc_sel;
    logic [6:0]  swal_count;
    logic [10:0] main_count;
    logic        ref_upd, main_upd;

    int checks = 0;
    int failures = 0;
    int n_ref = 0;
    int n_main = 0;
    bit done = 0;

    logic [13:0] e_rc = 14'd8;
    logic        e_ps = 1'b0;
    logic [6:0]  e_sw = 7'd0;
    logic [10:0] e_mc = 11'd0;

    always #5 clk = ~clk;

    ser_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .ref_count(ref_count), .presc_sel(presc_sel),
        .swal_count(swal_count), .main_count(main_count),
        .ref_upd(ref_upd), .main_upd(main_upd)
    );

    always @(negedge clk) if (rst_n) begin
        if (ref_upd)  n_ref++;
        if (main_upd) n_main++;
    end

    function automatic logic [13:0] clamp_rc(input logic [13:0] r);
        return (r < 14'd8) ? 14'd8 : r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [18:0] w, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            ser_dat = w[i];
            repeat (3) @(posedge clk);
            ser_clk = 1'b1;
            repeat (4) @(posedge clk);
            ser_clk = 1'b0;
            ser_dat = ~w[i];
            repeat (4) @(posedge clk);
        end
    endtask

    task automatic pulse_ld();
        ser_ld = 1'b0;
        repeat (5) @(posedge clk);
        ser_ld = 1'b1;
    endtask

    task automatic check_all(input string tag);
        chk(ref_count == e_rc, {tag, " ref_count"}, ref_count, e_rc);
        chk(presc_sel == e_ps, {tag, " presc_sel"}, presc_sel, e_ps);
        chk(swal_count == e_sw, {tag, " swal_count"}, swal_count, e_sw);
        chk(main_count == e_mc, {tag, " main_count"}, main_count, e_mc);
    endtask

    task automatic load_ref(input logic [13:0] r, input logic p);
        int nr0, nm0;
        shift_bits({3'b101, r, p, 1'b1}, 16);
        repeat (4) @(posedge clk);
        nr0 = n_ref; nm0 = n_main;
        pulse_ld();
        repeat (4) @(posedge clk);
        @(negedge clk);
        e_rc = clamp_rc(r); e_ps = p;
        check_all("R3 R7 R9");
        repeat (4) @(posedge clk);
        chk(n_ref == nr0 + 1, "R6 ref strobe count", n_ref - nr0, 1);
        chk(n_main == nm0, "R2 main strobe idle", n_main - nm0, 0);
    endtask

    task automatic load_main(input logic [10:0] n, input logic [6:0] a);
        int nr0, nm0;
        shift_bits({n, a, 1'b0}, 19);
        repeat (4) @(posedge clk);
        nr0 = n_ref; nm0 = n_main;
        pulse_ld();
        repeat (4) @(posedge clk);
        @(negedge clk);
        e_mc = n; e_sw = a;
        check_all("R4 R9");
        repeat (4) @(posedge clk);
        chk(n_main == nm0 + 1, "R6 main strobe count", n_main - nm0, 1);
        chk(n_ref == nr0, "R2 ref strobe idle", n_ref - nr0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        // R8: reset values and no transfer from an idle-high strobe
        check_all("R8 reset");
        chk(n_ref == 0 && n_main == 0, "R8 no strobe after reset", n_ref + n_main, 0);

        // R7 boundaries
        load_ref(14'd0, 1'b1);
        load_ref(14'd7, 1'b0);
        load_ref(14'd8, 1'b1);
        load_ref(14'd16383, 1'b0);
        // R4 boundaries
        load_main(11'd2047, 7'd127);
        load_main(11'd16, 7'd0);
        // R3: ref word after a full main word leaves stale high bits
        load_ref(14'h2AAA, 1'b1);

        // R5: strobe held high, another word shifted in, no transfer
        begin
            int nr0, nm0;
            nr0 = n_ref; nm0 = n_main;
            shift_bits({11'd1000, 7'd55, 1'b0}, 19);
            repeat (10) @(posedge clk);
            @(negedge clk);
            check_all("R5 held strobe");
            chk(n_ref + n_main == nr0 + nm0, "R5 no strobe while held",
                n_ref + n_main - nr0 - nm0, 0);
            pulse_ld();
            repeat (5) @(posedge clk);
            @(negedge clk);
            e_mc = 11'd1000; e_sw = 7'd55;
            check_all("R5 later rise");
        end

        // R1: falling edges alone shift nothing (data toggles while clock idles)
        begin
            for (int i = 0; i < 6; i++) begin
                ser_dat = ~ser_dat;
                repeat (4) @(posedge clk);
            end
            pulse_ld();
            repeat (5) @(posedge clk);
            @(negedge clk);
            check_all("R1 no shift without clock rise");
        end

        // Random mix
        for (int k = 0; k < 120; k++) begin
            if ($urandom_range(1, 0) == 1)
                load_ref(14'($urandom_range(16383, 0) >> $urandom_range(11, 0)),
                         1'($urandom_range(1, 0)));
            else
                load_main(11'($urandom_range(2047, 0)), 7'($urandom_range(127, 0)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule